// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Pattern Generator

This block produces the four gate commands for a full-bridge power stage under phase-shift control at a fixed switching frequency. A free-running period counter sets the switching frequency. The leading leg (outputs A and B) is locked to the start of each period. The lagging leg (outputs C and D) runs the same waveform but is displaced in time by a digital phase command. Each leg alternates its two switches at close to half-period duty. The energy delivered per cycle is set by how far the two legs overlap in time, not by pulse width.

Each leg has its own programmable dead time. The dead time holds back the turn-on of one switch after its partner in the same leg has turned off. A phase command below a fixed floor gives exactly zero shift. The period, phase and dead-time inputs are captured only at the start of a period, so a new setting never cuts a pulse short. Dropping the enable, for example on a fault, forces all four outputs low within one clock.

Top module: `psfb_pwm`

## Requirements
- R1: With period value P (P >= 4) and H = floor(P/2), output A rises once every P cycles. It stays high H - Dab cycles, where Dab is the A-B dead time. B rises H cycles after A rises and stays high P - H - Dab cycles.
- R2: The C-D leg uses the same pattern with its own dead time Dcd. C is high H - Dcd cycles and D is high P - H - Dcd cycles. D rises H cycles after C, modulo P.
- R3: The phase shift S equals the phase command, limited to at most H. C rises (S + Dcd - Dab) mod P cycles after A rises.
- R4: A phase command below 4 gives S = 0. A command of exactly 4 gives S = 4.
- R5: The two dead times act independently. A dead time larger than H - 1 is treated as H - 1.
- R6: A and B are never high together, and C and D are never high together, for every dead time including zero.
- R7: While en_i is low, all four outputs are low from the next clock on, and they are low during reset. When en_i rises, a new period starts and A first reads high Dab + 2 clocks later.
- R8: All four control inputs are captured only at a period boundary. A change during a period leaves that period's waveform unchanged, and the new values take effect from the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces all outputs low |
| period_i | input | CNT_W | Switching period in clock cycles |
| phase_i | input | CNT_W | Phase shift command of the lagging leg, in cycles |
| dt_ab_i | input | DT_W | Dead time of leading leg, in cycles |
| dt_cd_i | input | DT_W | Dead time of lagging leg, in cycles |
| out_a_o | output | 1 | Leading leg, first-half switch |
| out_b_o | output | 1 | Leading leg, second-half switch |
| out_c_o | output | 1 | Lagging leg, first-half switch |
| out_d_o | output | 1 | Lagging leg, second-half switch |

## Verification
The assertions check, on every cycle, the properties that hold at any instant. These are the mutual exclusion inside each leg, the forced-low state after enable drops, and the rule that captured settings stay constant inside a period. They also check the zero-shift floor and that the shift never passes half a period. Pulse widths, the offsets between edges, the dead-time clamp and the restart timing after enable depend on whole periods of waveform. Only the bench scenarios show those, by capturing full periods and measuring each edge position against values derived from the settings.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_drv_t;
endpackage

// File: rtl/psfb_period_ctr.sv
module psfb_period_ctr #(
  parameter int CNT_W  = 8,
  parameter int DT_W   = 6,
  parameter int PH_MIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [DT_W-1:0]  dt_ab_i,
  input  logic [DT_W-1:0]  dt_cd_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] shift_o,
  output logic [CNT_W-1:0] dt_ab_o,
  output logic [CNT_W-1:0] dt_cd_o
);
  localparam logic [CNT_W-1:0] PH_LIM = CNT_W'(PH_MIN);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, per_q, shift_q, dt_ab_q, dt_cd_q;
  logic [CNT_W-1:0] half_in, dt_lim, dt_ab_x, dt_cd_x;
  logic [CNT_W-1:0] dt_ab_c, dt_cd_c, shift_c;
  logic             wrap;

  assign half_in = period_i >> 1;
  assign dt_lim  = half_in - 1'b1;
  assign dt_ab_x = CNT_W'(dt_ab_i);
  assign dt_cd_x = CNT_W'(dt_cd_i);
  // keep at least one high cycle per switch
  assign dt_ab_c = (dt_ab_x > dt_lim) ? dt_lim : dt_ab_x;
  assign dt_cd_c = (dt_cd_x > dt_lim) ? dt_lim : dt_cd_x;

  always_comb begin
    if (phase_i < PH_LIM)       shift_c = '0;
    else if (phase_i > half_in) shift_c = half_in;
    else                        shift_c = phase_i;
  end

  assign wrap = run_q && (cnt_q == per_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      per_q   <= '0;
      shift_q <= '0;
      dt_ab_q <= '0;
      dt_cd_q <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q || wrap) begin
      run_q   <= 1'b1;
      cnt_q   <= '0;
      per_q   <= period_i;
      shift_q <= shift_c;
      dt_ab_q <= dt_ab_c;
      dt_cd_q <= dt_cd_c;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_o   = run_q;
  assign cnt_o   = cnt_q;
  assign per_o   = per_q;
  assign shift_o = shift_q;
  assign dt_ab_o = dt_ab_q;
  assign dt_cd_o = dt_cd_q;
endmodule

// File: rtl/psfb_leg.sv
module psfb_leg
  import psfb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] shift_i,
  input  logic [CNT_W-1:0] dt_i,
  output leg_drv_t         drv_o
);
  logic [CNT_W-1:0] half, pos;
  logic [CNT_W:0]   pos_wrap, lo_start;
  logic             hi_c, lo_c;
  leg_drv_t         drv_q;

  assign half     = per_i >> 1;
  assign pos_wrap = {1'b0, cnt_i} + {1'b0, per_i} - {1'b0, shift_i};
  assign pos      = (cnt_i >= shift_i) ? (cnt_i - shift_i) : pos_wrap[CNT_W-1:0];
  assign lo_start = {1'b0, half} + {1'b0, dt_i};

  // disjoint windows: [dt, half) and [half+dt, per)
  assign hi_c = act_i && (pos >= dt_i) && (pos < half);
  assign lo_c = act_i && ({1'b0, pos} >= lo_start) && (pos < per_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= '0;
    else         drv_q <= '{hi: hi_c, lo: lo_c};
  end

  assign drv_o = drv_q;
endmodule

// File: rtl/psfb_pwm.sv
module psfb_pwm
  import psfb_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DT_W   = 6,
  parameter int PH_MIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [DT_W-1:0]  dt_ab_i,
  input  logic [DT_W-1:0]  dt_cd_i,
  output logic             out_a_o,
  output logic             out_b_o,
  output logic             out_c_o,
  output logic             out_d_o
);
  localparam int NUM_LEGS = 2;

  logic             ctr_run;
  logic [CNT_W-1:0] ctr_cnt, ctr_per, ctr_shift, ctr_dt_ab, ctr_dt_cd;
  logic             leg_act;
  logic [CNT_W-1:0] leg_shift [NUM_LEGS];
  logic [CNT_W-1:0] leg_dt    [NUM_LEGS];
  leg_drv_t         drv       [NUM_LEGS];

  psfb_period_ctr #(
    .CNT_W (CNT_W),
    .DT_W  (DT_W),
    .PH_MIN(PH_MIN)
  ) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .period_i(period_i),
    .phase_i (phase_i),
    .dt_ab_i (dt_ab_i),
    .dt_cd_i (dt_cd_i),
    .run_o   (ctr_run),
    .cnt_o   (ctr_cnt),
    .per_o   (ctr_per),
    .shift_o (ctr_shift),
    .dt_ab_o (ctr_dt_ab),
    .dt_cd_o (ctr_dt_cd)
  );

  assign leg_act      = ctr_run & en_i;
  assign leg_shift[0] = '0;
  assign leg_shift[1] = ctr_shift;
  assign leg_dt[0]    = ctr_dt_ab;
  assign leg_dt[1]    = ctr_dt_cd;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_leg #(.CNT_W(CNT_W)) u_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (leg_act),
      .cnt_i  (ctr_cnt),
      .per_i  (ctr_per),
      .shift_i(leg_shift[g]),
      .dt_i   (leg_dt[g]),
      .drv_o  (drv[g])
    );
  end

  assign out_a_o = drv[0].hi;
  assign out_b_o = drv[0].lo;
  assign out_c_o = drv[1].hi;
  assign out_d_o = drv[1].lo;
endmodule

// File: rtl/psfb_chk.sv
module psfb_chk #(
  parameter int CNT_W  = 8,
  parameter int PH_MIN = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CNT_W-1:0] phase_i,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] per_i,
  input logic [CNT_W-1:0] shift_i,
  input logic [CNT_W-1:0] dt_ab_i,
  input logic [CNT_W-1:0] dt_cd_i,
  input logic             a_i,
  input logic             b_i,
  input logic             c_i,
  input logic             d_i
);
  localparam logic [CNT_W-1:0] PH_LIM = CNT_W'(PH_MIN);

  a_r6_ab_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_i && b_i));

  a_r6_cd_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(c_i && d_i));

  a_r7_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(a_i || b_i || c_i || d_i));

  a_r8_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && en_i && cnt_i != per_i - 1'b1)
      |=> $stable({per_i, shift_i, dt_ab_i, dt_cd_i}));

  a_r4_zero_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (!run_i || cnt_i == per_i - 1'b1) && phase_i < PH_LIM)
      |=> shift_i == '0);

  a_r3_shift_le_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> shift_i <= (per_i >> 1));
endmodule

bind psfb_pwm psfb_chk #(.CNT_W(CNT_W), .PH_MIN(PH_MIN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .phase_i(phase_i),
  .run_i  (ctr_run),
  .cnt_i  (ctr_cnt),
  .per_i  (ctr_per),
  .shift_i(ctr_shift),
  .dt_ab_i(ctr_dt_ab),
  .dt_cd_i(ctr_dt_cd),
  .a_i    (out_a_o),
  .b_i    (out_b_o),
  .c_i    (out_c_o),
  .d_i    (out_d_o)
);

// File: tb/sim_psfb_pwm.sv
`timescale 1ns/1ps
module sim_psfb_pwm;
  localparam int CNT_W = 8;
  localparam int DT_W  = 6;

  typedef struct {
    int    per;
    int    h;
    int    s;
    int    dab;
    int    dcd;
    string tag;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] phase_i = '0;
  logic [DT_W-1:0]  dt_ab_i = '0;
  logic [DT_W-1:0]  dt_cd_i = '0;
  logic out_a_o, out_b_o, out_c_o, out_d_o;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  bit   cap = 1'b0;
  exp_t q[$];
  logic [3:0] smp [0:511];

  always #4 clk_i = ~clk_i;

  psfb_pwm u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .period_i(period_i), .phase_i(phase_i),
    .dt_ab_i(dt_ab_i), .dt_cd_i(dt_cd_i),
    .out_a_o(out_a_o), .out_b_o(out_b_o),
    .out_c_o(out_c_o), .out_d_o(out_d_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int md(int x, int p);
    return ((x % p) + p) % p;
  endfunction

  function automatic exp_t mk(int per, int ph, int dab, int dcd, string tag);
    exp_t e;
    e.per = per;
    e.h   = per / 2;
    e.s   = (ph < 4) ? 0 : ((ph > e.h) ? e.h : ph);
    e.dab = (dab > e.h - 1) ? e.h - 1 : dab;
    e.dcd = (dcd > e.h - 1) ? e.h - 1 : dcd;
    e.tag = tag;
    return e;
  endfunction

  // circular rise index and high length of one channel in the captured window
  task automatic edge_of(int ch, int p, output int r, output int len);
    r = -1;
    len = 0;
    for (int i = 0; i < p; i++)
      if (smp[i][ch] && !smp[md(i - 1, p)][ch] && r < 0) r = i;
    if (r >= 0)
      for (int k = 0; k < p; k++) begin
        if (!smp[md(r + k, p)][ch]) break;
        len++;
      end
  endtask

  task automatic evaluate(exp_t e);
    int p, r, len, ov;
    p = e.per;
    ov = 0;
    for (int i = 0; i < p; i++)
      if ((smp[i][3] && smp[i][2]) || (smp[i][1] && smp[i][0])) ov++;
    chk("R6", {e.tag, " leg overlap cycles"}, ov, 0);
    chk("R1", {e.tag, " A period repeat"}, int'(smp[p][3] && !smp[p-1][3]), 1);
    edge_of(3, p, r, len);
    chk("R1", {e.tag, " A rise"}, r, 0);
    chk("R1", {e.tag, " A width"}, len, e.h - e.dab);
    edge_of(2, p, r, len);
    chk("R1", {e.tag, " B rise"}, r, e.h);
    chk("R1", {e.tag, " B width"}, len, p - e.h - e.dab);
    edge_of(1, p, r, len);
    chk("R3", {e.tag, " C rise"}, r, md(e.s + e.dcd - e.dab, p));
    chk("R2", {e.tag, " C width"}, len, e.h - e.dcd);
    edge_of(0, p, r, len);
    chk("R2", {e.tag, " D rise"}, r, md(e.s + e.h + e.dcd - e.dab, p));
    chk("R2", {e.tag, " D width"}, len, p - e.h - e.dcd);
  endtask

  // monitor: capture P+1 samples from an A rising edge, then compare
  initial begin
    exp_t cur;
    int   idx;
    logic prev_a;
    prev_a = 1'b0;
    idx = 0;
    forever begin
      @(negedge clk_i);
      if (!cap && q.size() > 0 && out_a_o && !prev_a) begin
        cur = q.pop_front();
        cap = 1'b1;
        idx = 0;
      end
      if (cap) begin
        smp[idx] = {out_a_o, out_b_o, out_c_o, out_d_o};
        idx++;
        if (idx == cur.per + 1) begin
          evaluate(cur);
          cap = 1'b0;
        end
      end
      prev_a = out_a_o;
    end
  end

  task automatic set_in(int per, int ph, int dab, int dcd);
    period_i = CNT_W'(per);
    phase_i  = CNT_W'(ph);
    dt_ab_i  = DT_W'(dab);
    dt_cd_i  = DT_W'(dcd);
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (q.size() > 0 || cap) @(negedge clk_i);
  endtask

  task automatic run_cfg(int per, int ph, int dab, int dcd, string tag);
    set_in(per, ph, dab, dcd);
    repeat (2 * per + 4) @(negedge clk_i);
    q.push_back(mk(per, ph, dab, dcd, tag));
    wait_idle();
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    chk("R7", "outputs in reset", int'({out_a_o, out_b_o, out_c_o, out_d_o}), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R7", "outputs with enable low", int'({out_a_o, out_b_o, out_c_o, out_d_o}), 0);

    set_in(40, 10, 2, 3);
    en_i = 1'b1;
    run_cfg(40, 10, 2, 3, "R3 base shift");
    run_cfg(40, 3, 2, 2, "R4 below floor");
    run_cfg(40, 4, 2, 2, "R4 at floor");
    run_cfg(40, 200, 1, 4, "R3 clamp half");
    run_cfg(41, 7, 0, 0, "R6 odd zero dt");
    run_cfg(20, 5, 60, 3, "R5 dt clamp");
    run_cfg(24, 12, 5, 1, "R5 independent dt");

    // R8: change inputs in mid period; the captured period must keep old values
    run_cfg(32, 6, 0, 2, "R8 before");
    q.push_back(mk(32, 6, 0, 2, "R8 mid change"));
    while (!cap) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    set_in(32, 14, 0, 5);
    wait_idle();
    repeat (2 * 32 + 4) @(negedge clk_i);
    q.push_back(mk(32, 14, 0, 5, "R8 after"));
    wait_idle();

    // R7: disable, then restart
    en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R7", "outputs after disable", int'({out_a_o, out_b_o, out_c_o, out_d_o}), 0);
    set_in(30, 9, 3, 3);
    en_i = 1'b1;
    n = 0;
    while (!out_a_o && n < 100) begin
      @(negedge clk_i);
      n++;
    end
    chk("R7", "clocks from enable to first A", n, 3 + 2);
    run_cfg(30, 9, 3, 3, "R7 after restart");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule